// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block prepares the second operand of a 32-bit ALU. It has no storage and no clock, so the operand and the shifter carry settle in the same cycle as the inputs. A 12-bit operand field and an immediate/register select choose between two forms:

- **Rotated constant.** An 8-bit constant rotated right by an even amount.
- **Shifted register.** The value of the register Rm passed through a logical left, logical right, arithmetic right or rotate-right shift. The shift amount comes either from a 5-bit field or from the low byte of a second register value. A zero amount in the 5-bit field is reused for special encodings: a shift by the full word, or a one-bit rotate through the carry flag.

The carry output is the last bit that leaves the word. When no bit leaves the word, the carry output is the incoming carry flag. The enclosing core reads the registers and owns any extra cycle that a register-supplied amount costs.

The block has no states. It is a chain of three pieces of logic: an amount decoder, a shift core and an immediate rotator, with a final select between the two forms.

Top module: `operand2_shifter`

## Requirements
- R1: With `i_imm_sel`=1, `o_operand` is the 8-bit constant from field bits [7:0], zero-extended and rotated right by 2×field[11:8]. `o_carry` is bit 31 of the result when that rotate is nonzero, and `i_carry` when it is zero.
- R2: With `i_imm_sel`=0, field[6:5] picks the shift: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. Field[4]=0 takes the amount from field[11:7]; field[4]=1 takes it from `i_rs_val`[7:0]. Field[3:0] has no effect on the outputs.
- R3: A logical left shift by y in 1..31 gives Rm<<y with zero fill and carry Rm[32−y]. A logical left shift with a 5-bit amount of 0 passes Rm unchanged with carry `i_carry`.
- R4: A logical or arithmetic right shift by y in 1..31 fills with zeros or with copies of Rm[31] respectively, and the carry is Rm[y−1].
- R5: A 5-bit amount of 0 with a logical right shift gives 0 with carry Rm[31]. With an arithmetic right shift it gives 32 copies of Rm[31] with carry Rm[31].
- R6: Rotate right by a 5-bit amount y in 1..31 moves bits leaving bit 0 into bit 31, with carry = result bit 31. A 5-bit amount of 0 gives {`i_carry`, Rm[31:1]} with carry Rm[0].
- R7: A register-supplied amount of 0 passes Rm and `i_carry` through unchanged for all four shift types.
- R8: For register-supplied amounts:
  - Exactly 32 gives 0 with carry Rm[0] for a left shift, and 0 with carry Rm[31] for a logical right shift.
  - Above 32, both logical shifts give 0 with carry 0.
  - An arithmetic right shift by 32 or more gives 32 copies of Rm[31] with carry Rm[31].
- R9: A register-supplied rotate uses the amount modulo 32. A nonzero multiple of 32 leaves Rm unchanged with carry Rm[31].
- R10: `i_rs_val`[31:8] has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_op_field | input | 12 | Operand field of the instruction |
| i_imm_sel | input | 1 | 1: rotated constant form; 0: shifted-register form |
| i_rm_val | input | 32 | Value of the register to be shifted |
| i_rs_val | input | 32 | Value of the register supplying a shift amount |
| i_carry | input | 1 | Current carry flag |
| o_operand | output | 32 | Prepared second operand |
| o_carry | output | 1 | Shifter carry-out |

## Verification
The bench builds the block at its default 32-bit word. At that width the 12-bit operand field has only 4096 codes. The bench drives every code in both forms, with both carry values and several Rm patterns. It then sweeps all 256 register-supplied amounts for each shift type, with and without junk in the upper bits of the amount register. Every special encoding, the exact-32 boundary and the modulo-32 rotate cases are therefore reached. The expected values come from shifting one bit position at a time.

// File: rtl/osh_pkg.sv
package osh_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    localparam int unsigned FIELD_W     = 12;
    localparam int unsigned REG_AMT_W   = 8;
    localparam int unsigned IMM8_W      = 8;
    localparam int unsigned ROT_FIELD_W = 4;

endpackage

// File: rtl/osh_amount_decode.sv
module osh_amount_decode
    import osh_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  shift_kind_e          kind,
    input  logic                 reg_sel,
    input  logic [SH_W-1:0]      imm_amt,
    input  logic [REG_AMT_W-1:0] reg_amt,
    output logic [REG_AMT_W-1:0] eff_amt,
    output logic                 rrx
);
    localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

    always_comb begin
        rrx     = 1'b0;
        eff_amt = REG_AMT_W'(imm_amt);
        if (reg_sel) begin
            eff_amt = reg_amt;
        end else if (imm_amt == '0) begin
            unique case (kind)
                SH_LSL: eff_amt = '0;
                SH_LSR: eff_amt = FULL_AMT;
                SH_ASR: eff_amt = FULL_AMT;
                SH_ROR: begin
                    eff_amt = 8'd1;
                    rrx     = 1'b1;
                end
                default: eff_amt = '0;
            endcase
        end
    end

    always_comb begin
        // R6: only a zero 5-bit rotate amount may request the carry rotate
        p_rrx_only_imm_ror_r6: assert (!rrx || (!reg_sel && kind == SH_ROR && imm_amt == '0))
            else $error("rrx raised outside its encoding");
        // R5: immediate zero right shifts become a full-word shift
        p_zero_right_full_r5: assert (reg_sel || imm_amt != '0 || !(kind == SH_LSR || kind == SH_ASR)
                                      || eff_amt == FULL_AMT)
            else $error("zero right shift not widened");
    end
endmodule

// File: rtl/osh_shift_core.sv
module osh_shift_core
    import osh_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]    val_in,
    input  shift_kind_e          kind,
    input  logic [REG_AMT_W-1:0] amt,
    input  logic                 rrx,
    input  logic                 c_in,
    output logic [DATA_W-1:0]    val_out,
    output logic                 c_out
);
    localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);
    localparam logic [SH_W:0]        FULL_ROT = (SH_W+1)'(DATA_W);

    logic [DATA_W:0]        lsl_w;
    logic [DATA_W:0]        lsr_w;
    logic signed [DATA_W:0] asr_src;
    logic signed [DATA_W:0] asr_w;
    logic [REG_AMT_W-1:0]   asr_amt;
    logic [SH_W-1:0]        rot_r;
    logic [SH_W:0]          rot_l;
    logic [DATA_W-1:0]      ror_v;
    logic                   over;

    always_comb begin
        over    = amt > FULL_AMT;
        lsl_w   = {1'b0, val_in} << amt;
        lsr_w   = {val_in, 1'b0} >> amt;
        asr_amt = over ? FULL_AMT : amt;
        asr_src = {val_in, 1'b0};
        asr_w   = asr_src >>> asr_amt;
        rot_r   = amt[SH_W-1:0];
        rot_l   = FULL_ROT - {1'b0, rot_r};
        ror_v   = (val_in >> rot_r) | (val_in << rot_l);
    end

    always_comb begin
        val_out = val_in;
        c_out   = c_in;
        if (rrx) begin
            val_out = {c_in, val_in[DATA_W-1:1]};
            c_out   = val_in[0];
        end else if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    val_out = over ? '0 : lsl_w[DATA_W-1:0];
                    c_out   = over ? 1'b0 : lsl_w[DATA_W];
                end
                SH_LSR: begin
                    val_out = over ? '0 : lsr_w[DATA_W:1];
                    c_out   = over ? 1'b0 : lsr_w[0];
                end
                SH_ASR: begin
                    val_out = asr_w[DATA_W:1];
                    c_out   = asr_w[0];
                end
                SH_ROR: begin
                    val_out = ror_v;
                    c_out   = ror_v[DATA_W-1];
                end
                default: begin
                    val_out = val_in;
                    c_out   = c_in;
                end
            endcase
        end
    end

    always_comb begin
        // R7: a zero amount leaves value and carry untouched
        p_zero_pass_r7: assert (rrx || amt != '0 || (val_out == val_in && c_out == c_in))
            else $error("zero amount altered the operand");
        // R8: logical shifts beyond the word clear value and carry
        p_over_clear_r8: assert (rrx || !(amt > FULL_AMT) || kind == SH_ROR || kind == SH_ASR
                                 || (val_out == '0 && !c_out))
            else $error("oversized logical shift left residue");
        // R9: rotation conserves the number of set bits
        p_rot_ones_r9: assert (rrx || kind != SH_ROR || $countones(val_out) == $countones(val_in))
            else $error("rotate changed bit count");
        // R6: rotate through carry conserves set bits across the 33-bit ring
        p_rrx_ring_r6: assert (!rrx || ($countones({c_out, val_out}) == $countones({c_in, val_in})))
            else $error("carry rotate lost a bit");
    end
endmodule

// File: rtl/osh_imm_rotator.sv
module osh_imm_rotator
    import osh_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [IMM8_W-1:0]      imm8,
    input  logic [ROT_FIELD_W-1:0] rot,
    input  logic                   c_in,
    output logic [DATA_W-1:0]      val_out,
    output logic                   c_out
);
    localparam logic [SH_W:0] FULL_ROT = (SH_W+1)'(DATA_W);

    logic [DATA_W-1:0] ext;
    logic [SH_W-1:0]   amt_r;
    logic [SH_W:0]     amt_l;

    always_comb begin
        ext     = DATA_W'(imm8);
        amt_r   = SH_W'({rot, 1'b0});
        amt_l   = FULL_ROT - {1'b0, amt_r};
        val_out = (ext >> amt_r) | (ext << amt_l);
        c_out   = (rot == '0) ? c_in : val_out[DATA_W-1];
    end

    always_comb begin
        // R1: the constant keeps its set bits whatever the rotation
        p_imm_ones_r1: assert ($countones(val_out) == $countones(imm8))
            else $error("constant rotate changed bit count");
        // R1: no rotation keeps the constant in the low byte and the flag
        p_imm_norot_r1: assert (rot != '0 || (val_out == DATA_W'(imm8) && c_out == c_in))
            else $error("unrotated constant disturbed");
    end
endmodule

// File: rtl/operand2_shifter.sv
module operand2_shifter
    import osh_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [11:0]       i_op_field,
    input  logic              i_imm_sel,
    input  logic [DATA_W-1:0] i_rm_val,
    input  logic [DATA_W-1:0] i_rs_val,
    input  logic              i_carry,
    output logic [DATA_W-1:0] o_operand,
    output logic              o_carry
);
    localparam int unsigned SH_W = $clog2(DATA_W);

    shift_kind_e          kind;
    logic [REG_AMT_W-1:0] eff_amt;
    logic                 rrx;
    logic [DATA_W-1:0]    sh_val;
    logic                 sh_c;
    logic [DATA_W-1:0]    imm_val;
    logic                 imm_c;
    logic                 unused_bits;

    assign kind        = shift_kind_e'(i_op_field[6:5]);
    assign unused_bits = ^{i_op_field[3:0], i_rs_val[DATA_W-1:REG_AMT_W]};

    osh_amount_decode #(.DATA_W(DATA_W)) u_dec (
        .kind    (kind),
        .reg_sel (i_op_field[4]),
        .imm_amt (i_op_field[11:12-SH_W]),
        .reg_amt (i_rs_val[REG_AMT_W-1:0]),
        .eff_amt (eff_amt),
        .rrx     (rrx)
    );

    osh_shift_core #(.DATA_W(DATA_W)) u_core (
        .val_in  (i_rm_val),
        .kind    (kind),
        .amt     (eff_amt),
        .rrx     (rrx),
        .c_in    (i_carry),
        .val_out (sh_val),
        .c_out   (sh_c)
    );

    osh_imm_rotator #(.DATA_W(DATA_W)) u_rot (
        .imm8    (i_op_field[IMM8_W-1:0]),
        .rot     (i_op_field[11:8]),
        .c_in    (i_carry),
        .val_out (imm_val),
        .c_out   (imm_c)
    );

    always_comb begin
        o_operand = i_imm_sel ? imm_val : sh_val;
        o_carry   = i_imm_sel ? imm_c : sh_c;
    end

    always_comb begin
        // R2: the constant form never depends on the register value
        p_imm_sel_r2: assert (!i_imm_sel || (o_operand == imm_val && o_carry == imm_c))
            else $error("form select mismatch");
    end
endmodule

// File: tb/operand2_shifter_tb.sv
module operand2_shifter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] op_field = '0;
    logic        imm_sel = 1'b0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        carry = 1'b0;
    logic [31:0] operand;
    logic        c_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    operand2_shifter u_dut (
        .i_op_field (op_field),
        .i_imm_sel  (imm_sel),
        .i_rm_val   (rm_val),
        .i_rs_val   (rs_val),
        .i_carry    (carry),
        .o_operand  (operand),
        .o_carry    (c_out)
    );

    // Reference: move one bit position per step, for as many steps as the amount.
    function automatic logic [32:0] model(input logic [11:0] f, input logic isel,
                                          input logic [31:0] v_in, input logic [31:0] rs,
                                          input logic c_in);
        logic [31:0] v;
        logic        c;
        int          n;
        int          kind;
        v = v_in;
        c = c_in;
        if (isel) begin
            v = {24'd0, f[7:0]};
            n = 2 * int'(f[11:8]);
            for (int i = 0; i < n; i++) begin
                c = v[0];
                v = {v[0], v[31:1]};
            end
            return {c, v};
        end
        kind = int'(f[6:5]);
        n    = f[4] ? int'(rs[7:0]) : int'(f[11:7]);
        if (!f[4] && n == 0) begin
            if (kind == 1 || kind == 2) n = 32;
            if (kind == 3) return {v[0], c, v[31:1]};
        end
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: begin c = v[31]; v = {v[30:0], 1'b0}; end
                1: begin c = v[0];  v = {1'b0, v[31:1]}; end
                2: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {c, v};
    endfunction

    function automatic string tag_of(input logic [11:0] f, input logic isel, input logic [31:0] rs);
        int n;
        if (isel) return "R1";
        if (f[4]) begin
            if (rs[31:8] != 0) return "R10";
            n = int'(rs[7:0]);
            if (n == 0) return "R7";
            if (f[6:5] == 2'b11) return "R9";
            if (n >= 32) return "R8";
            return "R2";
        end
        n = int'(f[11:7]);
        case (f[6:5])
            2'b00: return "R3";
            2'b11: return "R6";
            default: return (n == 0) ? "R5" : "R4";
        endcase
    endfunction

    task automatic check_now(input string tag);
        logic [32:0] exp;
        exp = model(op_field, imm_sel, rm_val, rs_val, carry);
        checks++;
        if (operand !== exp[31:0] || c_out !== exp[32]) begin
            failures++;
            $display("FAIL %s field=%h imm=%0b rm=%h rs=%h c=%0b actual=%h/%0b expected=%h/%0b",
                     tag, op_field, imm_sel, rm_val, rs_val, carry,
                     operand, c_out, exp[31:0], exp[32]);
        end
    endtask

    task automatic apply(input logic [11:0] f, input logic isel, input logic [31:0] rm,
                         input logic [31:0] rs, input logic c);
        @(negedge clk);
        op_field = f;
        imm_sel  = isel;
        rm_val   = rm;
        rs_val   = rs;
        carry    = c;
        #1;
        check_now(tag_of(f, isel, rs));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [31:0] PAT0 = 32'h8000_0004;
    localparam logic [31:0] PAT1 = 32'h7F3C_A5E1;
    localparam logic [31:0] PAT2 = 32'hFFFF_FFFF;
    localparam logic [31:0] PAT3 = 32'h0000_0001;

    initial begin
        logic [31:0] pats [4];
        pats[0] = PAT0; pats[1] = PAT1; pats[2] = PAT2; pats[3] = PAT3;

        // Reset state: all-zero inputs give a zero operand and zero carry.
        repeat (3) @(negedge clk);
        checks++;
        if (operand !== 32'd0 || c_out !== 1'b0) begin
            failures++;
            $display("FAIL R7 reset actual=%h/%0b expected=00000000/0", operand, c_out);
        end
        rst = 1'b0;

        // R1: every constant code and rotation, both carry values.
        for (int f = 0; f < 4096; f++)
            for (int c = 0; c < 2; c++)
                apply(12'(f), 1'b1, PAT1, 32'hFFFF_FFFF, c[0]);

        // R2..R6: every shifted-register code with a 5-bit amount; field[3:0] varies too (R2).
        for (int f = 0; f < 4096; f++) begin
            if (f[4] == 1'b0) begin
                for (int p = 0; p < 4; p++)
                    for (int c = 0; c < 2; c++)
                        apply(12'(f), 1'b0, pats[p], 32'h0000_0021, c[0]);
            end
        end

        // R7..R9: every register amount for each shift type.
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 256; a++)
                for (int p = 0; p < 4; p++)
                    for (int c = 0; c < 2; c++)
                        apply({5'd0, 2'(k), 1'b1, 4'h0}, 1'b0, pats[p], 32'(a), c[0]);

        // R10: junk above the low byte of the amount register.
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 256; a++)
                apply({5'd0, 2'(k), 1'b1, 4'h5}, 1'b0, PAT1, {24'hA5C3_96, 8'(a)}, a[0]);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule